// File: doc/BRIEF.md
# Source Operand Addressing Decoder

This block takes the 16-bit word of a two-operand instruction for a small 16-bit RISC processor and splits it into its fields. It also works out how the source operand is to be reached. Register numbers 2 and 3 do not always act as plain registers when paired with the source mode bits. Register 3 always yields a built-in constant, and so does register 2 under two of its mode codes. Register 2 also gives absolute addressing, and register 0 (the program counter) gives PC-relative or immediate addressing. The block reports the resolved source mode, any built-in constant, whether the source or the destination needs an extension word, how much the source register is post-incremented, and the total instruction length in words.

The decoder is a single registered stage. The instruction word is sampled on each rising clock edge, and every output reflects the word sampled at the previous edge, so all results appear one cycle after the word is presented. There is no state machine. The only sequential element is the output register, which is loaded every cycle (`load` transition) and cleared by reset (`idle` condition).

Top module: `src_operand_decoder`

## Requirements
- R1: One cycle after a word is sampled, the outputs carry its fields: opcode from bits [15:12], source register from [11:8], destination mode bit from [7], byte flag from [6] (1 = byte, 0 = word, the default), and destination register from [3:0]. The source mode bits are [5:4].
- R2: For source registers other than 0, 2 and 3, source mode bits 00/01/10/11 give mode codes 0 (register), 1 (indexed), 2 (indirect) and 3 (indirect with post-increment). For register 0 they give 0 (register), 4 (PC-relative), 2 (indirect) and 6 (immediate).
- R3: For source register 2, mode bits 00 give code 0 (register) and 01 give code 5 (absolute). Mode bits 10 and 11 give code 7 (constant) with values 0x0004 and 0x0008.
- R4: For source register 3, every mode bit pattern gives code 7 (constant) with values 0x0000, 0x0001, 0x0002 and 0xFFFF for mode bits 00, 01, 10 and 11. The constant-valid flag is 1 exactly when the code is 7, and the constant output is 0x0000 whenever the flag is 0.
- R5: The source extension flag is 1 exactly for codes 1, 4, 5 and 6. It is 0 for every constant.
- R6: The post-increment amount is 0 unless the code is 3 or 6. For those codes it is 2 for a word access, 2 whenever the source register is 0 or 1, and otherwise 1 for a byte access.
- R7: The destination mode code is 0 (register) when bit 7 is 0. When bit 7 is 1 it is 2 (PC-relative) for register 0, 3 (absolute) for register 2, and 1 (indexed) for any other register. The destination extension flag equals bit 7.
- R8: The length output equals 1 plus the source extension flag plus the destination extension flag, so it ranges from 1 to 3 words.
- R9: While reset is asserted (active low), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| opcode_o | output | 4 | Operation field |
| src_reg_o | output | 4 | Source register number |
| dst_reg_o | output | 4 | Destination register number |
| byte_o | output | 1 | 1 = byte access |
| src_mode_o | output | 3 | Resolved source mode code |
| const_vld_o | output | 1 | Source is a built-in constant |
| const_o | output | 16 | Built-in constant value |
| src_ext_o | output | 1 | Source needs an extension word |
| dst_mode_o | output | 2 | Resolved destination mode code |
| dst_ext_o | output | 1 | Destination needs an extension word |
| inc_amt_o | output | 2 | Source register post-increment |
| len_o | output | 2 | Instruction length in words |

## Verification
The bench builds the block with its default 16-bit word and 4-bit register number. At these values, every combination of source register and mode bits lies within a small space. The random stimulus is biased towards registers 0 to 3 and towards the post-increment mode, so that all special register cases, both access widths and the stack-pointer increment rule come up many times. Directed words cover the maximum length of three words, each constant value, and the case of a byte access with increment through register 0 and register 1.

// File: rtl/srcdec_pkg.sv
package srcdec_pkg;
    typedef enum logic [2:0] {
        SM_REG = 3'd0,
        SM_IDX = 3'd1,
        SM_IND = 3'd2,
        SM_INC = 3'd3,
        SM_SYM = 3'd4,
        SM_ABS = 3'd5,
        SM_IMM = 3'd6,
        SM_CON = 3'd7
    } src_mode_e;

    typedef enum logic [1:0] {
        DM_REG = 2'd0,
        DM_IDX = 2'd1,
        DM_SYM = 2'd2,
        DM_ABS = 2'd3
    } dst_mode_e;

    localparam int unsigned PC_NUM = 0;
    localparam int unsigned SP_NUM = 1;
    localparam int unsigned SR_NUM = 2;
    localparam int unsigned CG_NUM = 3;
endpackage

// File: rtl/srcdec_src.sv
module srcdec_src
    import srcdec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int REG_AW = 4
) (
    input  logic [REG_AW-1:0] sreg,
    input  logic [1:0]        as_bits,
    input  logic              is_byte,
    output src_mode_e         mode,
    output logic              cst_vld,
    output logic [WORD_W-1:0] cst,
    output logic              ext,
    output logic [1:0]        inc
);
    localparam logic [REG_AW-1:0] R_PC = REG_AW'(PC_NUM);
    localparam logic [REG_AW-1:0] R_SP = REG_AW'(SP_NUM);
    localparam logic [REG_AW-1:0] R_SR = REG_AW'(SR_NUM);
    localparam logic [REG_AW-1:0] R_CG = REG_AW'(CG_NUM);

    always_comb begin
        mode    = SM_REG;
        cst_vld = 1'b0;
        cst     = '0;
        if (sreg == R_CG) begin
            mode    = SM_CON;
            cst_vld = 1'b1;
            unique case (as_bits)
                2'b00: cst = WORD_W'(0);
                2'b01: cst = WORD_W'(1);
                2'b10: cst = WORD_W'(2);
                2'b11: cst = '1;
            endcase
        end else if (sreg == R_SR) begin
            unique case (as_bits)
                2'b00: mode = SM_REG;
                2'b01: mode = SM_ABS;
                2'b10: begin mode = SM_CON; cst_vld = 1'b1; cst = WORD_W'(4); end
                2'b11: begin mode = SM_CON; cst_vld = 1'b1; cst = WORD_W'(8); end
            endcase
        end else if (sreg == R_PC) begin
            unique case (as_bits)
                2'b00: mode = SM_REG;
                2'b01: mode = SM_SYM;
                2'b10: mode = SM_IND;
                2'b11: mode = SM_IMM;
            endcase
        end else begin
            unique case (as_bits)
                2'b00: mode = SM_REG;
                2'b01: mode = SM_IDX;
                2'b10: mode = SM_IND;
                2'b11: mode = SM_INC;
            endcase
        end
    end

    always_comb begin
        ext = (mode == SM_IDX) || (mode == SM_SYM) || (mode == SM_ABS) || (mode == SM_IMM);
        inc = 2'd0;
        if (mode == SM_INC || mode == SM_IMM) begin
            if (is_byte && sreg != R_PC && sreg != R_SP)
                inc = 2'd1;
            else
                inc = 2'd2;
        end
    end
endmodule

// File: rtl/srcdec_dst.sv
module srcdec_dst
    import srcdec_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic [REG_AW-1:0] dreg,
    input  logic              ad_bit,
    output dst_mode_e         mode,
    output logic              ext
);
    localparam logic [REG_AW-1:0] R_PC = REG_AW'(PC_NUM);
    localparam logic [REG_AW-1:0] R_SR = REG_AW'(SR_NUM);

    always_comb begin
        if (!ad_bit)
            mode = DM_REG;
        else if (dreg == R_PC)
            mode = DM_SYM;
        else if (dreg == R_SR)
            mode = DM_ABS;
        else
            mode = DM_IDX;
        ext = ad_bit;
    end
endmodule

// File: rtl/src_operand_decoder.sv
module src_operand_decoder
    import srcdec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int REG_AW = 4,
    parameter int OPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       instr_i,
    output logic [3:0]        opcode_o,
    output logic [3:0]        src_reg_o,
    output logic [3:0]        dst_reg_o,
    output logic              byte_o,
    output logic [2:0]        src_mode_o,
    output logic              const_vld_o,
    output logic [15:0]       const_o,
    output logic              src_ext_o,
    output logic [1:0]        dst_mode_o,
    output logic              dst_ext_o,
    output logic [1:0]        inc_amt_o,
    output logic [1:0]        len_o
);
    localparam int OPC_LSB  = WORD_W - OPC_W;
    localparam int SREG_LSB = OPC_LSB - REG_AW;
    localparam int AD_POS   = SREG_LSB - 1;
    localparam int BW_POS   = AD_POS - 1;
    localparam int AS_LSB   = BW_POS - 2;

    logic [OPC_W-1:0]  f_opc;
    logic [REG_AW-1:0] f_sreg, f_dreg;
    logic              f_ad, f_bw;
    logic [1:0]        f_as;

    always_comb begin
        f_opc  = instr_i[OPC_LSB +: OPC_W];
        f_sreg = instr_i[SREG_LSB +: REG_AW];
        f_ad   = instr_i[AD_POS];
        f_bw   = instr_i[BW_POS];
        f_as   = instr_i[AS_LSB +: 2];
        f_dreg = instr_i[REG_AW-1:0];
    end

    src_mode_e         s_mode;
    logic              s_cv, s_ext;
    logic [WORD_W-1:0] s_cst;
    logic [1:0]        s_inc;
    dst_mode_e         d_mode;
    logic              d_ext;

    srcdec_src #(.WORD_W(WORD_W), .REG_AW(REG_AW)) u_src (
        .sreg(f_sreg), .as_bits(f_as), .is_byte(f_bw),
        .mode(s_mode), .cst_vld(s_cv), .cst(s_cst), .ext(s_ext), .inc(s_inc)
    );

    srcdec_dst #(.REG_AW(REG_AW)) u_dst (
        .dreg(f_dreg), .ad_bit(f_ad), .mode(d_mode), .ext(d_ext)
    );

    logic [1:0] n_len;
    always_comb n_len = 2'd1 + {1'b0, s_ext} + {1'b0, d_ext};

    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_o    <= '0;
            src_reg_o   <= '0;
            dst_reg_o   <= '0;
            byte_o      <= 1'b0;
            src_mode_o  <= '0;
            const_vld_o <= 1'b0;
            const_o     <= '0;
            src_ext_o   <= 1'b0;
            dst_mode_o  <= '0;
            dst_ext_o   <= 1'b0;
            inc_amt_o   <= '0;
            len_o       <= '0;
            primed      <= 1'b0;
        end else begin
            opcode_o    <= f_opc;
            src_reg_o   <= f_sreg;
            dst_reg_o   <= f_dreg;
            byte_o      <= f_bw;
            src_mode_o  <= s_mode;
            const_vld_o <= s_cv;
            const_o     <= s_cst;
            src_ext_o   <= s_ext;
            dst_mode_o  <= d_mode;
            dst_ext_o   <= d_ext;
            inc_amt_o   <= s_inc;
            len_o       <= n_len;
            primed      <= 1'b1;
        end
    end

    p_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (src_reg_o == $past(instr_i[11:8]) && dst_reg_o == $past(instr_i[3:0])));
    p_sr_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && src_reg_o == 4'd2 && const_vld_o) |-> (const_o == 16'd4 || const_o == 16'd8));
    p_cg_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && src_reg_o == 4'd3) |-> (const_vld_o && src_mode_o == 3'd7));
    p_const_no_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        const_vld_o |-> !src_ext_o);
    p_inc_modes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_amt_o != 2'd0) |-> (src_mode_o == 3'd3 || src_mode_o == 3'd6));
    p_byte_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_amt_o == 2'd1) |-> (byte_o && src_reg_o > 4'd1));
    p_dst_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (dst_ext_o == (dst_mode_o != 2'd0)));
    p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_o == 2'd3) |-> (src_ext_o && dst_ext_o));
endmodule

// File: tb/src_operand_decoder_tb.sv
module src_operand_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  opc, sreg, dreg;
    logic        bw, cv, sext, dext;
    logic [2:0]  smode;
    logic [15:0] cst;
    logic [1:0]  dmode, inc, len;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    src_operand_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr),
        .opcode_o(opc), .src_reg_o(sreg), .dst_reg_o(dreg), .byte_o(bw),
        .src_mode_o(smode), .const_vld_o(cv), .const_o(cst), .src_ext_o(sext),
        .dst_mode_o(dmode), .dst_ext_o(dext), .inc_amt_o(inc), .len_o(len)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp, input logic [15:0] w);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_mode(input logic [15:0] w);
        logic [3:0] r = w[11:8];
        logic [1:0] a = w[5:4];
        if (r == 4'd3) return 3'd7;
        if (r == 4'd2) return (a == 2'b00) ? 3'd0 : (a == 2'b01) ? 3'd5 : 3'd7;
        if (r == 4'd0) return (a == 2'b00) ? 3'd0 : (a == 2'b01) ? 3'd4 : (a == 2'b10) ? 3'd2 : 3'd6;
        return {1'b0, a};
    endfunction

    function automatic logic [15:0] ref_cst(input logic [15:0] w);
        logic [3:0] r = w[11:8];
        logic [1:0] a = w[5:4];
        if (r == 4'd3) return (a == 2'b00) ? 16'h0 : (a == 2'b01) ? 16'h1 : (a == 2'b10) ? 16'h2 : 16'hFFFF;
        if (r == 4'd2 && a == 2'b10) return 16'h4;
        if (r == 4'd2 && a == 2'b11) return 16'h8;
        return 16'h0;
    endfunction

    task automatic apply(input logic [15:0] w);
        logic [2:0] m;
        logic       e_sx, e_dx;
        logic [1:0] e_inc, e_dm;
        @(negedge clk) instr = w;
        @(posedge clk);
        @(negedge clk);
        m     = ref_mode(w);
        e_sx  = (m == 3'd1 || m == 3'd4 || m == 3'd5 || m == 3'd6);
        e_dx  = w[7];
        e_dm  = !w[7] ? 2'd0 : (w[3:0] == 4'd0) ? 2'd2 : (w[3:0] == 4'd2) ? 2'd3 : 2'd1;
        e_inc = (m != 3'd3 && m != 3'd6) ? 2'd0 : (w[6] && w[11:8] > 4'd1) ? 2'd1 : 2'd2;
        chk("R1 opcode", {12'd0, opc}, {12'd0, w[15:12]}, w);
        chk("R1 regs", {8'd0, sreg, dreg}, {8'd0, w[11:8], w[3:0]}, w);
        chk("R1 byte", {15'd0, bw}, {15'd0, w[6]}, w);
        chk("R2/R3 mode", {13'd0, smode}, {13'd0, m}, w);
        chk("R4 const_vld", {15'd0, cv}, {15'd0, (m == 3'd7)}, w);
        chk("R4 const", cst, ref_cst(w), w);
        chk("R5 src_ext", {15'd0, sext}, {15'd0, e_sx}, w);
        chk("R6 inc", {14'd0, inc}, {14'd0, e_inc}, w);
        chk("R7 dst_mode", {14'd0, dmode}, {14'd0, e_dm}, w);
        chk("R7 dst_ext", {15'd0, dext}, {15'd0, e_dx}, w);
        chk("R8 len", {14'd0, len}, 16'(1 + e_sx + e_dx), w);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [15:0] dir [20];
        seed = $urandom(32'd1234);
        instr = 16'hB3F5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset holds outputs at zero
        chk("R9 reset", {opc, sreg, dreg, bw, cv, sext, dext}, 16'h0, instr);
        chk("R9 reset", cst | {13'd0, smode} | {14'd0, dmode} | {14'd0, inc} | {14'd0, len}, 16'h0, instr);
        rst_n = 1'b1;
        dir = '{16'h4504, 16'h4580, 16'h40D0, 16'h4031, 16'h40B2, 16'h4305,
                16'h5315, 16'h8325, 16'h4303, 16'h4335, 16'h4225, 16'h4235,
                16'h4215, 16'h4175, 16'h4575, 16'h4535, 16'h4070, 16'h4EC2,
                16'h4290, 16'h4192};
        foreach (dir[i]) apply(dir[i]);
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if ($urandom_range(0, 1) == 1) w[11:8] = 4'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) w[5:4] = 2'b11;
            if ($urandom_range(0, 3) == 0) w[3:0] = 4'($urandom_range(0, 2));
            apply(w);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule